// File: doc/BRIEF.md
# Daisy-chain interrupt priority controller

This block is the interrupt logic of a peripheral that has six internal interrupt sources. It links them into an external priority daisy chain. Each source raises a level request flag. The block turns enabled requests into pending latches and asserts an active-low interrupt request while its chain input `iei` is high. On the host acknowledge cycle (machine-cycle-one and I/O-request strobes both low), it answers with a vector byte and moves the winning source into an in-service latch.

Inside the block the sources sit in a fixed priority order. Index 0 is the highest: channel A receive, channel A transmit, channel A external/status, channel B receive, channel B transmit, channel B external/status. Sources are held off while a higher-priority source is in service, and a higher-priority source may interrupt a lower one that is in service. The block watches opcode fetches on the data bus so that it can see the two-byte return-from-interrupt sequence. The prefix byte 0xED temporarily lets the chain pass past pending requests that have not been acknowledged. The following byte 0x4D ends the service of the highest-priority source in service.

A three-address write port loads the base vector, the per-source enables and the status-affects-vector flag. All pins are plain control or status signals; there is no streaming data path and no back-pressure.

Top module: `irq_chain_ctl`

## Requirements
- R1: Source index 0 has the highest priority and index 5 the lowest. An acknowledge serves the lowest-index source that is pending or in service, and it does so only when that source is pending and not in service.
- R2: `ieo` equals `iei` when no source is pending and none is in service. Otherwise `ieo` is low, except in the case covered by R5.
- R3: A source becomes pending only at a clock edge where `m1_n` is high, and it then copies `src_req & enable & ~in_service`. While `m1_n` is low the pending set is held, so a request that rises in that time shows on `int_n` only after `m1_n` returns high.
- R4: The acknowledge starts at the first clock edge where `m1_n` and `iorq_n` are both low. If `iei` is high and a source wins under R1, the block sets that source's in-service latch, and `vec_oe` goes high with the vector on `vec_out` until `m1_n` rises. If no source wins, `vec_oe` stays low.
- R5: An opcode fetch is a `m1_n` low period with `iorq_n` high. The byte is decoded when `m1_n` rises. After a fetch of 0xED and until the next decoded fetch, `ieo` is `iei` AND no source in service, so pending sources that have not been acknowledged are ignored.
- R6: A fetch of 0x4D that directly follows a fetch of 0xED, with `iei` high, clears only the in-service latch of the lowest-index source in service. The same byte without the prefix, or with `iei` low, clears nothing.
- R7: Config address 2 bit 0 is the status-affects-vector flag. With the flag clear, the vector is the base vector unchanged. With the flag set, it is {base[7:4], code, base[0]}, where code is 3'b110, 3'b100, 3'b101, 3'b010, 3'b000, 3'b001 for sources 0 to 5.
- R8: After reset all enables, the pending set, the in-service set and the flag are zero. Requests then cause no interrupt, and `ieo` follows `iei`.
- R9: `int_n` is low exactly when `iei` is high and the lowest-index source that is pending or in service is pending.
- R10: Config address 1 bits 5:0 are per-source enables; a source whose enable is 0 never becomes pending. Address 0 is the base vector.
- R11: Nesting: while a lower-priority source is in service, a higher-priority source can still be acknowledged, and lower-priority pending sources stay blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 6 | Level request flags, index 0 highest priority |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 2 | 0 base vector, 1 enables, 2 vector-mode flag |
| cfg_wdata | input | 8 | Config write data |
| m1_n | input | 1 | Machine-cycle-one strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| bus_din | input | 8 | Data bus as seen during opcode fetch |
| iei | input | 1 | Daisy-chain enable in |
| ieo | output | 1 | Daisy-chain enable out |
| int_n | output | 1 | Interrupt request, active low |
| vec_oe | output | 1 | Vector drive enable during acknowledge |
| vec_out | output | 8 | Vector byte (zero when not driven) |

## Verification
The bench raises a request while `m1_n` is low. A design that did not hold the pending set would assert `int_n` before the strobe ends. The bench also sends 0x4D without the prefix, and the return sequence with `iei` low. A design that decoded too freely would clear an in-service latch, and a later acknowledge of the wrong source would show it. Nested service is checked by having the second return clear the higher source first, so that a cleared lower latch would unblock the wrong request. The prefix-only fetch checks that `ieo` rises for a source that is pending but not acknowledged and stays low while any source is in service.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int NSRC = 6;
  localparam int VW   = 8;
  localparam int CW   = 3;

  typedef logic [CW-1:0] code_t;

  // per-source routine code used when the vector carries the source
  function automatic code_t src_code(input int idx);
    case (idx)
      0:       return 3'b110;
      1:       return 3'b100;
      2:       return 3'b101;
      3:       return 3'b010;
      4:       return 3'b000;
      default: return 3'b001;
    endcase
  endfunction
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  input  logic [N-1:0] ius,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)   pend[i] <= 1'b0;
      else if (upd) pend[i] <= req[i] & en[i] & ~ius[i];
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] flags,
  output logic [N-1:0] first,
  output logic         any
);
  always_comb begin
    first = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (flags[i] && !any) begin
        first[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_reti_snoop.sv
module irq_reti_snoop #(
  parameter int         DW      = 8,
  parameter logic [7:0] OP_PFX  = 8'hED,
  parameter logic [7:0] OP_RET  = 8'h4D
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m1_n,
  input  logic          iorq_n,
  input  logic [DW-1:0] bus_din,
  input  logic          iei,
  output logic          ed_mode,
  output logic          reti_hit
);
  logic          m1_q, ack_seen_q, ed_q;
  logic [DW-1:0] opc_q;
  logic          m1_rise, dec;

  assign m1_rise = m1_n & ~m1_q;
  assign dec     = m1_rise & ~ack_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1_q       <= 1'b1;
      ack_seen_q <= 1'b0;
      ed_q       <= 1'b0;
      opc_q      <= '0;
    end else begin
      m1_q <= m1_n;
      if (!m1_n && !iorq_n) ack_seen_q <= 1'b1;
      else if (m1_rise)     ack_seen_q <= 1'b0;
      if (!m1_n && iorq_n)  opc_q <= bus_din;
      if (dec)              ed_q <= (opc_q == DW'(OP_PFX));
    end
  end

  assign ed_mode  = ed_q;
  assign reti_hit = dec & ed_q & (opc_q == DW'(OP_RET)) & iei;
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
  import irq_chain_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [VW-1:0]   cfg_wdata,
  input  logic            m1_n,
  input  logic            iorq_n,
  input  logic [VW-1:0]   bus_din,
  input  logic            iei,
  output logic            ieo,
  output logic            int_n,
  output logic            vec_oe,
  output logic [VW-1:0]   vec_out
);
  logic [VW-1:0]   base_q, vec_q;
  logic [NSRC-1:0] en_q, ius_q, pend_q;
  logic            sav_q, iorq_q, hit_q;
  logic [NSRC-1:0] win, ius_top;
  logic            win_any, ius_any;
  logic            ed_mode, reti_hit, ack_edge, ack_ok;
  code_t           win_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      en_q   <= '0;
      sav_q  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0:    base_q <= cfg_wdata;
        2'd1:    en_q   <= cfg_wdata[NSRC-1:0];
        2'd2:    sav_q  <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  irq_pend_bank #(.N(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .upd(m1_n), .req(src_req),
    .en(en_q), .ius(ius_q), .pend(pend_q)
  );

  irq_prio_pick #(.N(NSRC)) u_win (
    .flags(pend_q | ius_q), .first(win), .any(win_any)
  );

  irq_prio_pick #(.N(NSRC)) u_top (
    .flags(ius_q), .first(ius_top), .any(ius_any)
  );

  irq_reti_snoop #(.DW(VW)) u_snoop (
    .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n),
    .bus_din(bus_din), .iei(iei), .ed_mode(ed_mode), .reti_hit(reti_hit)
  );

  always_comb begin
    win_code = '0;
    for (int i = 0; i < NSRC; i++)
      if (win[i]) win_code = src_code(i);
  end

  assign ack_edge = ~m1_n & ~iorq_n & iorq_q;
  assign ack_ok   = iei & win_any & |(win & pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ius_q  <= '0;
      iorq_q <= 1'b1;
      hit_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      iorq_q <= iorq_n;
      if (ack_edge && ack_ok) begin
        ius_q <= ius_q | win;
        hit_q <= 1'b1;
        vec_q <= sav_q ? {base_q[VW-1:4], win_code, base_q[0]} : base_q;
      end else begin
        if (m1_n) hit_q <= 1'b0;
        if (reti_hit && ius_any) ius_q <= ius_q & ~ius_top;
      end
    end
  end

  assign int_n   = ~(iei & |(win & pend_q));
  assign ieo     = ed_mode ? (iei & ~|ius_q) : (iei & ~|ius_q & ~|pend_q);
  assign vec_oe  = hit_q & ~m1_n & ~iorq_n;
  assign vec_out = vec_oe ? vec_q : '0;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         m1_n,
  input logic         iorq_n,
  input logic         iei,
  input logic         ieo,
  input logic         int_n,
  input logic         vec_oe,
  input logic [N-1:0] pend,
  input logic [N-1:0] ius
);
  // R2
  ius_blocks_ieo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius) |-> !ieo);
  // R2
  idle_passes_ieo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ius == '0 && pend == '0) |-> (ieo == iei));
  // R3
  pend_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!m1_n) |-> $stable(pend));
  // R4
  vec_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (!m1_n && !iorq_n));
  // R9
  int_needs_iei_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> iei);
  // R6
  single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(ius) & ~ius) <= 1);
endmodule

bind irq_chain_ctl irq_chain_chk #(.N(irq_chain_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .m1_n(m1_n), .iorq_n(iorq_n), .iei(iei),
  .ieo(ieo), .int_n(int_n), .vec_oe(vec_oe), .pend(pend_q), .ius(ius_q)
);

// File: tb/irq_chain_ctl_test.sv
`timescale 1ns/1ps
module irq_chain_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_req = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       m1_n = 1'b1, iorq_n = 1'b1;
  logic [7:0] bus_din = '0;
  logic       iei = 1'b1;
  logic       ieo, int_n, vec_oe;
  logic [7:0] vec_out;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [5:0] m_en = '0, m_pend = '0, m_ius = '0;
  logic [7:0] m_base = '0;
  logic       m_sav = 1'b0, m_ed = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_ctl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .m1_n(m1_n), .iorq_n(iorq_n),
    .bus_din(bus_din), .iei(iei), .ieo(ieo), .int_n(int_n),
    .vec_oe(vec_oe), .vec_out(vec_out)
  );

  function automatic logic [2:0] exp_code(input int i);
    case (i)
      0: return 3'b110; 1: return 3'b100; 2: return 3'b101;
      3: return 3'b010; 4: return 3'b000; default: return 3'b001;
    endcase
  endfunction

  function automatic int first_of(input logic [5:0] f);
    for (int i = 0; i < 6; i++) if (f[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_int_n();
    int w = first_of(m_pend | m_ius);
    return !(iei && w >= 0 && m_pend[w]);
  endfunction

  function automatic logic exp_ieo();
    if (m_ed) return iei && (m_ius == '0);
    return iei && (m_ius == '0) && (m_pend == '0);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    tick();
    m_pend = src_req & m_en & ~m_ius;
  endtask

  task automatic outs(input string r);
    chk({r, " int_n"}, int'(int_n), int'(exp_int_n()));
    chk({r, " ieo"}, int'(ieo), int'(exp_ieo()));
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    case (a)
      2'd0: m_base = d;
      2'd1: m_en = d[5:0];
      2'd2: m_sav = d[0];
      default: ;
    endcase
    settle();
  endtask

  task automatic set_req(input logic [5:0] v);
    src_req = v;
    settle();
  endtask

  task automatic fetch(input logic [7:0] b);
    int t;
    m1_n = 1'b0; bus_din = b;
    tick(); tick();
    m1_n = 1'b1;
    tick();
    if (b == 8'hED) m_ed = 1'b1;
    else begin
      if (m_ed && b == 8'h4D && iei) begin
        t = first_of(m_ius);
        if (t >= 0) m_ius[t] = 1'b0;
      end
      m_ed = 1'b0;
    end
    settle();
  endtask

  task automatic reti(input string r);
    fetch(8'hED);
    fetch(8'h4D);
    outs(r);
  endtask

  task automatic ack(input string r);
    int w;
    logic expect_hit;
    logic [7:0] ev;
    w = first_of(m_pend | m_ius);
    expect_hit = iei && w >= 0 && m_pend[w];
    ev = '0;
    if (expect_hit)
      ev = m_sav ? {m_base[7:4], exp_code(w), m_base[0]} : m_base;
    m1_n = 1'b0; tick();
    iorq_n = 1'b0; tick();
    chk({r, " vec_oe"}, int'(vec_oe), int'(expect_hit));
    chk({r, " vec_out"}, int'(vec_out), int'(ev));
    if (expect_hit) m_ius[w] = 1'b1;
    m1_n = 1'b1; iorq_n = 1'b1;
    tick();
    settle();
    outs(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R8 reset state
    chk("R8 reset int_n", int'(int_n), 1);
    chk("R8 reset ieo", int'(ieo), 1);
    chk("R8 reset vec_oe", int'(vec_oe), 0);
    set_req(6'h3F);
    outs("R8 requests ignored after reset");
    ack("R8 no vector after reset");

    // R10 enables and base vector
    cfg(2'd0, 8'hA1);
    cfg(2'd1, 8'h3F);
    outs("R10 R2 R9 all enabled");
    iei = 1'b0; tick();
    outs("R9 iei low blocks int");
    ack("R4 no ack with iei low");
    iei = 1'b1; tick();
    // R1 R4 raw vector
    ack("R1 R4 ack highest source raw vector");
    // R7 source-coded vector
    cfg(2'd2, 8'h01);
    reti("R6 return clears source 0");
    ack("R7 coded vector source 0");
    reti("R6 return clears");
    // R11 nesting
    set_req(6'b001000);
    ack("R7 coded vector source 3");
    set_req(6'b001010);
    outs("R11 higher request unblocked");
    ack("R11 nested ack source 1");
    set_req(6'b000000);
    reti("R6 nested return clears higher first");
    set_req(6'b000010);
    outs("R6 R11 source 1 pending again after clear");
    // R6 return without prefix and with iei low
    fetch(8'h4D);
    outs("R6 bare 4D ignored");
    iei = 1'b0; tick();
    reti("R6 return with iei low");
    iei = 1'b1; tick();
    outs("R6 iei restored");
    set_req(6'b000000);
    reti("R6 cleanup");
    reti("R6 cleanup");
    // R5 prefix opens chain past unacknowledged pending
    set_req(6'b000001);
    outs("R2 pending forces ieo low");
    fetch(8'hED);
    chk("R5 prefix lets ieo follow iei", int'(ieo), 1);
    fetch(8'h00);
    outs("R5 mode ends on next fetch");
    ack("R4 ack source 0");
    fetch(8'hED);
    chk("R5 prefix with in-service keeps ieo low", int'(ieo), 0);
    fetch(8'h4D);
    outs("R6 completes return");
    // R3 freeze during m1
    set_req(6'b000000);
    cfg(2'd1, 8'h3F);
    m1_n = 1'b0; bus_din = 8'h00; tick();
    src_req = 6'b000100; tick();
    chk("R3 request held off during m1", int'(int_n), 1);
    tick();
    chk("R3 request still held off", int'(int_n), 1);
    m1_n = 1'b1; tick();
    chk("R3 request seen after m1 high", int'(int_n), 0);
    m_ed = 1'b0;
    settle();
    outs("R3 settled");
    // R10 masked source
    cfg(2'd1, 8'b111011);
    outs("R10 disabled source dropped");

    // random phase
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom_range(0, 6));
      case (op)
        0, 1: set_req(6'($urandom));
        2: ack("R1 R4 R7 random ack");
        3: reti("R6 random return");
        4: cfg(2'($urandom_range(0, 2)), 8'($urandom));
        5: begin iei = 1'($urandom); tick(); end
        default: begin
          logic [7:0] b = 8'($urandom);
          if (b == 8'hED) b = 8'h00;
          fetch(b);
        end
      endcase
      outs("R2 R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule